// File: doc/BRIEF.md
# Strobed Handshake Parallel Port

This block provides two 8-bit parallel ports, A and B, that a CPU programs through a small register interface. Each port exchanges data with a peripheral over its pins using an active-low ready line and an active-low strobe line. A port can run as an output port, an input port, a bidirectional port, or a bit-control port in which every pin has its own direction.

Every completed transfer produces a one-cycle interrupt request pulse for that port. In bidirectional mode, port A sends and receives over the same pins. Port A's own ready and strobe lines handle the outgoing direction. Port B's ready and strobe lines are taken over for the incoming direction, so while this happens port B can only work as a bit-control port.

Strobe inputs are brought into the system clock domain by a two-flop synchronizer. Transactions are recognised on the synchronized rising edge. Address bit 1 selects the port (0 = A, 1 = B). Address bit 0 selects the data register (0) or the control register (1). `wr` and `rd` are single-cycle qualifiers: one asserted cycle is one access.

Top module: `hsk_pport`

## Requirements
- R1: After reset both ports are in input mode with ready asserted (ready pin low), all output enables 0, no interrupt pulse, and a data read of port A returns 0.
- R2: A control write whose low nibble is 4'hF is a mode word, and bits 7:6 give the mode (0 output, 1 input, 2 bidirectional, 3 bit-control). A control read returns the mode in bits 7:6 and zeros elsewhere. A mode change deasserts output-direction ready.
- R3: In output mode all eight output enables are 1 and the pins carry the output latch. A CPU data write loads the latch and asserts ready.
- R4: In output mode, a synchronized rising edge of the strobe while ready is asserted deasserts ready and raises the port's interrupt for exactly one cycle. A strobe while ready is deasserted has no effect and raises no interrupt.
- R5: In input mode the output enables are 0. While ready is asserted and the strobe is low, the pins are captured into the input latch. The strobe's rising edge deasserts ready and raises one interrupt pulse. A CPU data read returns the input latch and reasserts ready.
- R6: In input mode, while ready is deasserted, a strobe neither changes the input latch nor raises an interrupt.
- R7: In bidirectional mode, port A's output enables are all 1 only while port A's strobe is low, and 0 otherwise. A data write asserts port A's ready. The strobe's rising edge deasserts it and pulses port A's interrupt.
- R8: In bidirectional mode, port B's ready pin shows port A's input ready. Port B's strobe low captures port A's pins into port A's input latch. Its rising edge deasserts that ready and pulses port A's interrupt, not port B's. A read of port A data reasserts it.
- R9: A bidirectional mode word written to port B is ignored. A bit-control mode word written to port B is accepted only while port A is in bidirectional mode.
- R10: After a bit-control mode word, the next control write to that port is a direction mask (1 = input bit). The output enables equal the inverted mask. A data read returns pin values on input bits and latch values on output bits.
- R11: When the outgoing and incoming transfers of bidirectional mode complete in the same cycle, both readies deassert and port A gives exactly one interrupt pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select |
| wr | input | 1 | Write qualifier, one cycle per access |
| rd | input | 1 | Read qualifier, one cycle per access |
| addr | input | 2 | Bit 1 port select, bit 0 data/control select |
| wdata | input | 8 | CPU write data |
| rdata | output | 8 | CPU read data, zero when not reading |
| a_in | input | 8 | Port A pin input values |
| a_out | output | 8 | Port A pin drive values |
| a_oe | output | 8 | Port A per-pin output enable |
| a_rdy_n | output | 1 | Port A ready, active low |
| a_stb_n | input | 1 | Port A strobe, active low |
| b_in | input | 8 | Port B pin input values |
| b_out | output | 8 | Port B pin drive values |
| b_oe | output | 8 | Port B per-pin output enable |
| b_rdy_n | output | 1 | Port B ready, active low |
| b_stb_n | input | 1 | Port B strobe, active low |
| irq_a | output | 1 | Port A interrupt request pulse |
| irq_b | output | 1 | Port B interrupt request pulse |

## Verification
In bidirectional mode, the completion of an outgoing transfer and the completion of an incoming transfer can land in the same clock cycle, and both feed port A's single interrupt line. The bench arms both directions first: it writes port A data and leaves the input latch empty. It then pulls both strobes low on the same falling clock edge and releases them together. A correct result is both ready pins high and exactly one interrupt pulse counted on port A, with none on port B.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    localparam int DW       = 8;
    localparam int SYNC_STG = 2;
    localparam logic [3:0] MODE_KEY = 4'hF;

    typedef enum logic [1:0] {
        PM_OUT   = 2'd0,
        PM_IN    = 2'd1,
        PM_BIDIR = 2'd2,
        PM_BITS  = 2'd3
    } pmode_e;

    typedef struct packed {
        logic lvl;   // synchronized strobe level, 1 = idle
        logic rise;  // one-cycle rising-edge indication
    } stb_s;

    function automatic logic drives_out(pmode_e m);
        return (m == PM_OUT) || (m == PM_BIDIR);
    endfunction

    function automatic logic takes_in(pmode_e m);
        return (m == PM_IN) || (m == PM_BIDIR);
    endfunction

endpackage

// File: rtl/hsk_sync.sv
module hsk_sync
    import hsk_pkg::*;
#(
    parameter int STAGES = SYNC_STG
) (
    input  logic clk,
    input  logic rst,
    input  logic stb_n,
    output stb_s stb
);
    logic [STAGES-1:0] chain;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], stb_n};
            prev  <= chain[STAGES-1];
        end
    end

    always_comb begin
        stb.lvl  = chain[STAGES-1];
        stb.rise = chain[STAGES-1] & ~prev;
    end
endmodule

// File: rtl/hsk_chan.sv
module hsk_chan
    import hsk_pkg::*;
#(
    parameter int W        = DW,
    parameter bit BIDIR_OK = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ctl_we,
    input  logic         dat_we,
    input  logic         dat_rd,
    input  logic [W-1:0] wdata,
    input  logic         peer_bidir,
    input  stb_s         o_stb,
    input  stb_s         i_stb,
    input  logic [W-1:0] pins_in,
    output pmode_e       mode,
    output logic [W-1:0] pins_out,
    output logic [W-1:0] pins_oe,
    output logic [W-1:0] rd_val,
    output logic         o_rdy,
    output logic         i_rdy,
    output logic         irq
);
    logic [W-1:0] out_lat;
    logic [W-1:0] in_lat;
    logic [W-1:0] mask;
    logic         mask_pend;
    pmode_e       new_mode;
    logic         mode_ok;
    logic         mode_chg;
    logic         o_done;
    logic         i_done;

    always_comb begin
        new_mode = pmode_e'(wdata[W-1:W-2]);
        case (new_mode)
            PM_BIDIR: mode_ok = BIDIR_OK;
            PM_BITS:  mode_ok = BIDIR_OK || peer_bidir;
            default:  mode_ok = 1'b1;
        endcase
        mode_chg = ctl_we && !mask_pend && (wdata[3:0] == MODE_KEY) && mode_ok;
        o_done   = drives_out(mode) && o_rdy && o_stb.rise;
        i_done   = takes_in(mode) && i_rdy && i_stb.rise;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode      <= PM_IN;
            mask      <= '0;
            mask_pend <= 1'b0;
            out_lat   <= '0;
            in_lat    <= '0;
            o_rdy     <= 1'b0;
            i_rdy     <= 1'b1;
            irq       <= 1'b0;
        end else begin
            irq <= o_done | i_done;

            if (ctl_we && mask_pend) begin
                mask      <= wdata;
                mask_pend <= 1'b0;
            end else if (mode_chg) begin
                mode      <= new_mode;
                mask_pend <= (new_mode == PM_BITS);
            end

            if (dat_we)
                out_lat <= wdata;

            if (takes_in(mode) && i_rdy && !i_stb.lvl)
                in_lat <= pins_in;

            if (mode_chg)
                o_rdy <= 1'b0;
            else if (dat_we && drives_out(mode))
                o_rdy <= 1'b1;
            else if (o_done)
                o_rdy <= 1'b0;

            if (mode_chg)
                i_rdy <= takes_in(new_mode);
            else if (i_done)
                i_rdy <= 1'b0;
            else if (dat_rd && takes_in(mode))
                i_rdy <= 1'b1;
        end
    end

    always_comb begin
        pins_out = out_lat;
        case (mode)
            PM_OUT:   pins_oe = '1;
            PM_IN:    pins_oe = '0;
            PM_BIDIR: pins_oe = o_stb.lvl ? '0 : '1;
            default:  pins_oe = ~mask;
        endcase
        case (mode)
            PM_OUT:  rd_val = out_lat;
            PM_BITS: rd_val = (pins_in & mask) | (out_lat & ~mask);
            default: rd_val = in_lat;
        endcase
    end

    AST_ORDY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        (dat_we && drives_out(mode) && !ctl_we) |=> o_rdy) else $error("o_rdy"); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        ($fell(o_rdy) && !$past(ctl_we)) |-> irq) else $error("irq"); // R4

    AST_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!i_rdy && !ctl_we) |=> $stable(in_lat)) else $error("in_lat"); // R6

    AST_IN_REARM: assert property (@(posedge clk) disable iff (rst)
        (dat_rd && takes_in(mode) && !ctl_we && !(i_rdy && i_stb.rise)) |=> i_rdy)
        else $error("i_rdy"); // R5
endmodule

// File: rtl/hsk_pport.sv
module hsk_pport
    import hsk_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         cs,
    input  logic         wr,
    input  logic         rd,
    input  logic [1:0]   addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [DW-1:0] a_in,
    output logic [DW-1:0] a_out,
    output logic [DW-1:0] a_oe,
    output logic         a_rdy_n,
    input  logic         a_stb_n,
    input  logic [DW-1:0] b_in,
    output logic [DW-1:0] b_out,
    output logic [DW-1:0] b_oe,
    output logic         b_rdy_n,
    input  logic         b_stb_n,
    output logic         irq_a,
    output logic         irq_b
);
    localparam int NPORT = 2;
    localparam stb_s IDLE = '{lvl: 1'b1, rise: 1'b0};

    stb_s        s_stb [NPORT];
    logic [NPORT-1:0] raw_stb;
    logic [NPORT-1:0] ctl_we, dat_we, dat_rd;
    pmode_e      mode_a, mode_b;
    logic [DW-1:0] val_a, val_b;
    logic        ordy_a, irdy_a, ordy_b, irdy_b;
    logic        a_bidir;
    stb_s        a_i_stb, b_o_stb, b_i_stb;

    assign raw_stb = {b_stb_n, a_stb_n};

    for (genvar p = 0; p < NPORT; p++) begin : g_sync
        hsk_sync #(.STAGES(SYNC_STG)) u_sync (
            .clk   (clk),
            .rst   (rst),
            .stb_n (raw_stb[p]),
            .stb   (s_stb[p])
        );
        assign ctl_we[p] = cs && wr && (addr[1] == p[0]) &&  addr[0];
        assign dat_we[p] = cs && wr && (addr[1] == p[0]) && !addr[0];
        assign dat_rd[p] = cs && rd && (addr[1] == p[0]) && !addr[0];
    end

    always_comb begin
        a_bidir = (mode_a == PM_BIDIR);
        a_i_stb = a_bidir ? s_stb[1] : s_stb[0];
        b_o_stb = a_bidir ? IDLE : s_stb[1];
        b_i_stb = a_bidir ? IDLE : s_stb[1];
    end

    hsk_chan #(.W(DW), .BIDIR_OK(1'b1)) u_chan_a (
        .clk        (clk),
        .rst        (rst),
        .ctl_we     (ctl_we[0]),
        .dat_we     (dat_we[0]),
        .dat_rd     (dat_rd[0]),
        .wdata      (wdata),
        .peer_bidir (1'b0),
        .o_stb      (s_stb[0]),
        .i_stb      (a_i_stb),
        .pins_in    (a_in),
        .mode       (mode_a),
        .pins_out   (a_out),
        .pins_oe    (a_oe),
        .rd_val     (val_a),
        .o_rdy      (ordy_a),
        .i_rdy      (irdy_a),
        .irq        (irq_a)
    );

    hsk_chan #(.W(DW), .BIDIR_OK(1'b0)) u_chan_b (
        .clk        (clk),
        .rst        (rst),
        .ctl_we     (ctl_we[1]),
        .dat_we     (dat_we[1]),
        .dat_rd     (dat_rd[1]),
        .wdata      (wdata),
        .peer_bidir (a_bidir),
        .o_stb      (b_o_stb),
        .i_stb      (b_i_stb),
        .pins_in    (b_in),
        .mode       (mode_b),
        .pins_out   (b_out),
        .pins_oe    (b_oe),
        .rd_val     (val_b),
        .o_rdy      (ordy_b),
        .i_rdy      (irdy_b),
        .irq        (irq_b)
    );

    always_comb begin
        case (mode_a)
            PM_OUT, PM_BIDIR: a_rdy_n = ~ordy_a;
            PM_IN:            a_rdy_n = ~irdy_a;
            default:          a_rdy_n = 1'b1;
        endcase
        if (a_bidir)
            b_rdy_n = ~irdy_a;
        else begin
            case (mode_b)
                PM_OUT:  b_rdy_n = ~ordy_b;
                PM_IN:   b_rdy_n = ~irdy_b;
                default: b_rdy_n = 1'b1;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        if (cs && rd) begin
            case (addr)
                2'd0:    rdata = val_a;
                2'd1:    rdata = {mode_a, {(DW-2){1'b0}}};
                2'd2:    rdata = val_b;
                default: rdata = {mode_b, {(DW-2){1'b0}}};
            endcase
        end
    end

    AST_B_NEVER_BIDIR: assert property (@(posedge clk) disable iff (rst)
        mode_b != PM_BIDIR) else $error("mode_b"); // R9

    AST_BITS_NEEDS_A: assert property (@(posedge clk) disable iff (rst)
        (mode_b == PM_BITS && $past(mode_b) != PM_BITS) |-> $past(mode_a) == PM_BIDIR)
        else $error("bits"); // R9
endmodule

// File: tb/tb_hsk_pport.sv
module tb_hsk_pport;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic [7:0] a_in = '0, a_out, a_oe;
    logic [7:0] b_in = '0, b_out, b_oe;
    logic       a_rdy_n, b_rdy_n, irq_a, irq_b;
    logic       a_stb_n = 1'b1, b_stb_n = 1'b1;

    int n_run = 0;
    int n_fail = 0;
    int cnt_a = 0;
    int cnt_b = 0;

    hsk_pport dut (
        .clk(clk), .rst(rst), .cs(cs), .wr(wr), .rd(rd), .addr(addr),
        .wdata(wdata), .rdata(rdata),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe), .a_rdy_n(a_rdy_n), .a_stb_n(a_stb_n),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe), .b_rdy_n(b_rdy_n), .b_stb_n(b_stb_n),
        .irq_a(irq_a), .irq_b(irq_b)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (!rst && irq_a) cnt_a <= cnt_a + 1;
        if (!rst && irq_b) cnt_b <= cnt_b + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic pulse_a();
        @(negedge clk) a_stb_n = 1'b0;
        wait_cyc(4);
        a_stb_n = 1'b1;
        wait_cyc(5);
    endtask

    task automatic pulse_b();
        @(negedge clk) b_stb_n = 1'b0;
        wait_cyc(4);
        b_stb_n = 1'b1;
        wait_cyc(5);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 a_rdy_n", a_rdy_n, 0);
        check("R1 b_rdy_n", b_rdy_n, 0);
        check("R1 oe", {a_oe, b_oe}, 0);
        check("R1 irq", cnt_a + cnt_b, 0);
        bus_rd(2'd0, d);
        check("R1 data A", d, 0);
    endtask

    task automatic t_output();
        logic [7:0] d;
        int c0;
        bus_wr(2'd1, 8'h0F);
        bus_rd(2'd1, d);
        check("R2 ctl read", d, 8'h00);
        wait_cyc(1);
        check("R3 oe", a_oe, 8'hFF);
        check("R2 rdy after mode", a_rdy_n, 1);
        bus_wr(2'd0, 8'hA5);
        wait_cyc(1);
        check("R3 pins", a_out, 8'hA5);
        check("R3 rdy", a_rdy_n, 0);
        c0 = cnt_a;
        pulse_a();
        check("R4 rdy done", a_rdy_n, 1);
        check("R4 irq one", cnt_a - c0, 1);
        pulse_a();
        check("R4 ignored", cnt_a - c0, 1);
    endtask

    task automatic t_input();
        logic [7:0] d;
        int c0;
        bus_wr(2'd3, 8'h4F);
        wait_cyc(1);
        check("R5 oe", b_oe, 8'h00);
        check("R5 rdy", b_rdy_n, 0);
        b_in = 8'h3C;
        c0 = cnt_b;
        pulse_b();
        check("R5 rdy done", b_rdy_n, 1);
        check("R5 irq", cnt_b - c0, 1);
        b_in = 8'h99;
        pulse_b();
        check("R6 no irq", cnt_b - c0, 1);
        bus_rd(2'd2, d);
        check("R6 latch held", d, 8'h3C);
        wait_cyc(1);
        check("R5 rearm", b_rdy_n, 0);
    endtask

    task automatic t_bidir();
        logic [7:0] d;
        int ca, cb;
        bus_wr(2'd3, 8'h8F);
        bus_rd(2'd3, d);
        check("R9 B bidir ignored", d, 8'h40);
        bus_wr(2'd1, 8'h8F);
        wait_cyc(1);
        check("R7 oe idle", a_oe, 8'h00);
        check("R7 rdy idle", a_rdy_n, 1);
        check("R8 b_rdy is A input", b_rdy_n, 0);
        bus_wr(2'd0, 8'h5A);
        wait_cyc(1);
        check("R7 rdy", a_rdy_n, 0);
        ca = cnt_a; cb = cnt_b;
        @(negedge clk) a_stb_n = 1'b0;
        wait_cyc(4);
        check("R7 oe drive", a_oe, 8'hFF);
        check("R7 pins", a_out, 8'h5A);
        a_stb_n = 1'b1;
        wait_cyc(5);
        check("R7 oe release", a_oe, 8'h00);
        check("R7 rdy done", a_rdy_n, 1);
        check("R7 irq", cnt_a - ca, 1);
        a_in = 8'hC3;
        pulse_b();
        check("R8 rdy done", b_rdy_n, 1);
        check("R8 irq A", cnt_a - ca, 2);
        check("R8 no irq B", cnt_b - cb, 0);
        bus_rd(2'd0, d);
        check("R8 data", d, 8'hC3);
        wait_cyc(1);
        check("R8 rearm", b_rdy_n, 0);
    endtask

    task automatic t_both();
        logic [7:0] d;
        int ca;
        bus_wr(2'd0, 8'h11);
        wait_cyc(1);
        ca = cnt_a;
        @(negedge clk) begin a_stb_n = 1'b0; b_stb_n = 1'b0; end
        wait_cyc(4);
        a_stb_n = 1'b1; b_stb_n = 1'b1;
        wait_cyc(6);
        check("R11 a_rdy", a_rdy_n, 1);
        check("R11 b_rdy", b_rdy_n, 1);
        check("R11 one irq", cnt_a - ca, 1);
        bus_rd(2'd0, d);
    endtask

    task automatic t_bits();
        logic [7:0] d;
        bus_wr(2'd3, 8'hCF);
        bus_rd(2'd3, d);
        check("R9 B bits accepted", d, 8'hC0);
        bus_wr(2'd3, 8'hF0);
        wait_cyc(1);
        check("R10 oe", b_oe, 8'h0F);
        bus_wr(2'd2, 8'h5A);
        b_in = 8'h3C;
        bus_rd(2'd2, d);
        check("R10 mixed read", d, 8'h3A);
        bus_wr(2'd1, 8'h4F);
        bus_wr(2'd3, 8'h0F);
        bus_wr(2'd3, 8'hCF);
        bus_rd(2'd3, d);
        check("R9 B bits rejected", d, 8'h00);
    endtask

    initial begin
        wait_cyc(3);
        rst = 1'b0;
        wait_cyc(2);
        t_reset();
        t_output();
        t_input();
        t_bidir();
        t_both();
        t_bits();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule